// File: doc/BRIEF.md
# Serial EEPROM Slave Command Engine

This block is the slave side of a three-wire serial EEPROM port. It watches a chip select, a serial clock and a serial data input, all already synchronous to the system clock, and drives one serial data output with an output-enable flag that models the tri-state pin. After chip select rises while the serial clock is low, the first 1 sampled on a rising serial clock edge is taken as the start bit. Two opcode bits and an 8-bit word address follow. From these the engine decodes a read, a single-word write, a page write of up to four words, a whole-array write, and the setting or clearing of a write-enable latch.

Reads are served from an internal 256 x 16 word array. One dummy zero comes first, and then words stream out with no gap for as long as chip select stays high. Write-type instructions collect their data words and then hand them to an external programming sequencer through a start/done handshake. The sequencer also applies any area protection and answers with an accept flag. The array takes the new data only when the sequencer reports completion and accepts the write. While programming runs, chip select can be raised to read busy (0) or ready (1) on the data output.

Top module: `mw_eeprom_engine`

## Requirements
- R1: After reset the output enable is low, no programming request is issued, the write-enable latch is clear, and every array word reads as 0000h.
- R2: An instruction begins only when chip select rises while the serial clock is low. Zeros sampled before the first 1 are skipped. After the start bit, the first opcode bit received is the MSB: 10 = read, 01 = word write, 11 = page write, 00 = extended. For extended instructions the first two address bits choose the operation: 11 = set latch, 00 = clear latch, 01 = whole-array write.
- R3: A read drives one dummy 0 after the rising edge that samples the last address bit. The addressed word then follows MSB first, one bit per rising serial clock edge.
- R4: While chip select stays high, a read continues into the next address with no dummy bit, and wraps from address FFh to 00h.
- R5: The set-latch instruction enables write-type instructions and the clear-latch instruction disables them. Reads work whatever the latch holds.
- R6: A write-type instruction has no effect when the latch is clear or the write-enable pin is low.
- R7: A programming request is issued only when chip select falls after the last data bit of a word and before the next rising serial clock edge. If chip select falls earlier or later, nothing is issued. The request reports op 0 = word, 1 = page, 2 = whole array, the start address, the word count, and the data with word i at bits [16i+15:16i].
- R8: A page write accepts 1 to 4 words. A further rising edge after the fourth word cancels the instruction. Word i is stored at the page address whose two low bits are (start + i) mod 4, and the upper address bits do not change.
- R9: A whole-array write reports a count of 1 and, once accepted, stores its single data word at every address.
- R10: From a request until done, raising chip select drives 0 on the data output and ignores all serial input. After done, the output shows 1 until a start bit is decoded or chip select falls.
- R11: The array is updated only when done arrives with the accept flag high. A rejected request leaves the array unchanged.
- R12: The output enable is low whenever chip select is low, and also while chip select is high with no read or status in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, standing in for power-on detection |
| cs_i | input | 1 | Chip select, synchronous to clk |
| sck_i | input | 1 | Serial clock, synchronous to clk |
| sdi_i | input | 1 | Serial data in |
| wen_pin_i | input | 1 | External write-enable pin |
| sdo_o | output | 1 | Serial data out / busy-ready status |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| prog_start_o | output | 1 | One-cycle programming request |
| prog_op_o | output | 2 | Request kind: 0 word, 1 page, 2 whole array |
| prog_addr_o | output | 8 | Start address of the request |
| prog_cnt_o | output | 3 | Number of data words (1 to 4) |
| prog_data_o | output | 64 | Data words, word i at bits [16i+15:16i] |
| prog_done_i | input | 1 | Sequencer completion pulse |
| prog_ok_i | input | 1 | Sequencer accepts the write (protection passed) |

## Verification
Two things can share a single cycle in this engine: the status display, which holds the output at 0 while busy, and the instruction decoder, which sees serial edges arriving during that same busy window. The bench provokes this by clocking a complete read instruction into the bus while a programming request is still pending. It then checks that the output stays at busy with the enable high, and that no read starts. When done arrives, the output must flip to ready, stay at ready through a zero bit, and be released only once a fresh start bit is decoded. A read of the written word afterwards confirms that the ignored instruction left no trace.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

   typedef enum logic [1:0] {
      PG_WORD = 2'd0,
      PG_PAGE = 2'd1,
      PG_ALL  = 2'd2
   } pg_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_OPC,
      ST_ADDR,
      ST_RD,
      ST_DATA,
      ST_ARM,
      ST_DEAD
   } mw_state_e;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_PAGE  = 2'b11;
   localparam logic [1:0] OPC_EXT   = 2'b00;

   localparam logic [1:0] EXT_SET   = 2'b11;
   localparam logic [1:0] EXT_CLR   = 2'b00;
   localparam logic [1:0] EXT_ALL   = 2'b01;

endpackage

// File: rtl/mw_pin_edges.sv
module mw_pin_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   output logic cs_q_o,
   output logic sck_rise_o,
   output logic cs_rise_o
);

   logic cs_q;
   logic sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b0;
         sck_q <= 1'b0;
      end else begin
         cs_q  <= cs_i;
         sck_q <= sck_i;
      end
   end

   assign cs_q_o     = cs_q;
   assign sck_rise_o = sck_i & ~sck_q;
   // a new frame only counts when select rises with the serial clock low
   assign cs_rise_o  = cs_i & ~cs_q & ~sck_i;

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array
   import mw_eeprom_pkg::*;
#(
   parameter  int AW    = 8,
   parameter  int DW    = 16,
   parameter  int PW    = 4,
   localparam int PB    = $clog2(PW),
   localparam int DEPTH = 1 << AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  pg_op_e            op_i,
   input  logic [AW-1:0]     base_addr_i,
   input  logic [PB:0]       cnt_i,
   input  logic [PW*DW-1:0]  wbuf_i,
   input  logic [AW-1:0]     rd_addr_i,
   output logic [DW-1:0]     rd_data_o
);

   logic [DW-1:0] rows_w [DEPTH];

   for (genvar r = 0; r < DEPTH; r++) begin : g_row
      localparam logic [AW-1:0] RA = AW'(r);
      logic [PB-1:0] off;
      logic          hit;
      logic [DW-1:0] wdata;
      logic [DW-1:0] row_q;

      assign off = RA[PB-1:0] - base_addr_i[PB-1:0];

      always_comb begin
         hit   = 1'b0;
         wdata = wbuf_i[DW-1:0];
         unique case (op_i)
            PG_WORD: hit = (RA == base_addr_i);
            PG_PAGE: begin
               hit   = (RA[AW-1:PB] == base_addr_i[AW-1:PB]) &&
                       ({1'b0, off} < cnt_i);
               wdata = wbuf_i[int'(off)*DW +: DW];
            end
            PG_ALL:  hit = 1'b1;
            default: hit = 1'b0;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              row_q <= '0;
         else if (commit_i && hit) row_q <= wdata;
      end

      assign rows_w[r] = row_q;
   end

   assign rd_data_o = rows_w[rd_addr_i];

endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
   import mw_eeprom_pkg::*;
#(
   parameter  int AW   = 8,
   parameter  int DW   = 16,
   parameter  int PW   = 4,
   localparam int PB   = $clog2(PW),
   localparam int MAXB = (AW > DW) ? AW : DW,
   localparam int CW   = $clog2(MAXB) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              cs_q_i,
   input  logic              cs_rise_i,
   input  logic              sck_rise_i,
   input  logic              sdi_i,
   input  logic              wen_pin_i,
   input  logic              prog_done_i,
   input  logic [DW-1:0]     rd_data_i,
   output logic [AW-1:0]     rd_addr_o,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic              prog_start_o,
   output pg_op_e            prog_op_o,
   output logic [AW-1:0]     prog_addr_o,
   output logic [PB:0]       prog_cnt_o,
   output logic [PW*DW-1:0]  prog_data_o,
   output logic              wel_o,
   output logic              busy_o
);

   mw_state_e           state_q;
   logic [CW-1:0]       cnt_q;
   logic [1:0]          opc_q;
   logic [AW-1:0]       addr_q;
   pg_op_e              op_q;
   logic [DW-1:0]       dsh_q;
   logic [DW-1:0]       rsh_q;
   logic [PW*DW-1:0]    buf_q;
   logic [PB:0]         nw_q;
   logic                sdo_q;
   logic                wel_q;
   logic                busy_q;
   logic                stat_q;
   logic                start_q;

   logic [AW-1:0]       addr_nxt;
   logic [DW-1:0]       dsh_nxt;
   logic [1:0]          opc_nxt;
   logic                may_write;

   assign addr_nxt  = {addr_q[AW-2:0], sdi_i};
   assign dsh_nxt   = {dsh_q[DW-2:0], sdi_i};
   assign opc_nxt   = {opc_q[0], sdi_i};
   assign may_write = wel_q & wen_pin_i;
   assign rd_addr_o = (state_q == ST_ADDR) ? addr_nxt : addr_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         opc_q   <= '0;
         addr_q  <= '0;
         op_q    <= PG_WORD;
         dsh_q   <= '0;
         rsh_q   <= '0;
         buf_q   <= '0;
         nw_q    <= '0;
         sdo_q   <= 1'b0;
         wel_q   <= 1'b0;
         busy_q  <= 1'b0;
         stat_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (prog_done_i && busy_q) busy_q <= 1'b0;

         if (!cs_i) begin
            state_q <= ST_IDLE;
            if (!busy_q) stat_q <= 1'b0;
            // deselect inside the window after a complete word launches
            if (state_q == ST_ARM && may_write && !busy_q) begin
               start_q <= 1'b1;
               busy_q  <= 1'b1;
               stat_q  <= 1'b1;
            end
         end else if (cs_rise_i) begin
            state_q <= ST_START;
         end else if (sck_rise_i) begin
            unique case (state_q)
               ST_START: begin
                  if (!busy_q && sdi_i) begin
                     state_q <= ST_OPC;
                     stat_q  <= 1'b0;
                     cnt_q   <= '0;
                  end
               end
               ST_OPC: begin
                  opc_q <= opc_nxt;
                  if (cnt_q == CW'(1)) begin
                     state_q <= ST_ADDR;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_ADDR: begin
                  addr_q <= addr_nxt;
                  if (cnt_q != CW'(AW - 1)) begin
                     cnt_q <= cnt_q + 1'b1;
                  end else begin
                     cnt_q   <= '0;
                     nw_q    <= '0;
                     state_q <= ST_DEAD;
                     unique case (opc_q)
                        OPC_READ: begin
                           rsh_q   <= rd_data_i;
                           sdo_q   <= 1'b0;
                           state_q <= ST_RD;
                        end
                        OPC_WRITE: begin
                           op_q <= PG_WORD;
                           if (may_write) state_q <= ST_DATA;
                        end
                        OPC_PAGE: begin
                           op_q <= PG_PAGE;
                           if (may_write) state_q <= ST_DATA;
                        end
                        default: begin
                           unique case (addr_nxt[AW-1:AW-2])
                              EXT_SET: wel_q <= 1'b1;
                              EXT_CLR: wel_q <= 1'b0;
                              EXT_ALL: begin
                                 op_q <= PG_ALL;
                                 if (may_write) state_q <= ST_DATA;
                              end
                              default: state_q <= ST_DEAD;
                           endcase
                        end
                     endcase
                  end
               end
               ST_RD: begin
                  sdo_q <= rsh_q[DW-1];
                  if (cnt_q == CW'(DW - 1)) begin
                     rsh_q  <= rd_data_i;
                     addr_q <= addr_q + 1'b1;
                     cnt_q  <= '0;
                  end else begin
                     rsh_q <= {rsh_q[DW-2:0], 1'b0};
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_DATA: begin
                  dsh_q <= dsh_nxt;
                  if (cnt_q == CW'(DW - 1)) begin
                     buf_q[int'(nw_q[PB-1:0])*DW +: DW] <= dsh_nxt;
                     nw_q    <= nw_q + 1'b1;
                     state_q <= ST_ARM;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_ARM: begin
                  // another edge: next page word, or the window was missed
                  if (op_q == PG_PAGE && nw_q < (PB+1)'(PW)) begin
                     dsh_q   <= dsh_nxt;
                     cnt_q   <= CW'(1);
                     state_q <= ST_DATA;
                  end else begin
                     state_q <= ST_DEAD;
                  end
               end
               default: state_q <= state_q;
            endcase
         end
      end
   end

   assign sdo_o        = stat_q ? ~busy_q : sdo_q;
   assign sdo_oe_o     = cs_q_i & (stat_q | (state_q == ST_RD));
   assign prog_start_o = start_q;
   assign prog_op_o    = op_q;
   assign prog_addr_o  = addr_q;
   assign prog_cnt_o   = nw_q;
   assign prog_data_o  = buf_q;
   assign wel_o        = wel_q;
   assign busy_o       = busy_q;

endmodule

// File: rtl/mw_eeprom_engine.sv
module mw_eeprom_engine
   import mw_eeprom_pkg::*;
#(
   parameter  int AW = 8,
   parameter  int DW = 16,
   parameter  int PW = 4,
   localparam int PB = $clog2(PW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              sck_i,
   input  logic              sdi_i,
   input  logic              wen_pin_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic              prog_start_o,
   output logic [1:0]        prog_op_o,
   output logic [AW-1:0]     prog_addr_o,
   output logic [PB:0]       prog_cnt_o,
   output logic [PW*DW-1:0]  prog_data_o,
   input  logic              prog_done_i,
   input  logic              prog_ok_i
);

   if (AW < 3 || AW > 16) begin : g_bad_aw
      $error("AW must lie in 3..16");
   end
   if (DW < 2 || DW > 64) begin : g_bad_dw
      $error("DW must lie in 2..64");
   end
   if (PW < 2 || (1 << PB) != PW || PB >= AW) begin : g_bad_pw
      $error("PW must be a power of two, at least 2, below the depth");
   end

   logic          cs_q_w;
   logic          sck_rise_w;
   logic          cs_rise_w;
   logic [AW-1:0] rd_addr_w;
   logic [DW-1:0] rd_data_w;
   pg_op_e        op_w;
   logic          wel_w;
   logic          busy_w;
   logic          commit_w;

   mw_pin_edges u_edges (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_i       (cs_i),
      .sck_i      (sck_i),
      .cs_q_o     (cs_q_w),
      .sck_rise_o (sck_rise_w),
      .cs_rise_o  (cs_rise_w)
   );

   mw_cmd_fsm #(.AW(AW), .DW(DW), .PW(PW)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_i         (cs_i),
      .cs_q_i       (cs_q_w),
      .cs_rise_i    (cs_rise_w),
      .sck_rise_i   (sck_rise_w),
      .sdi_i        (sdi_i),
      .wen_pin_i    (wen_pin_i),
      .prog_done_i  (prog_done_i),
      .rd_data_i    (rd_data_w),
      .rd_addr_o    (rd_addr_w),
      .sdo_o        (sdo_o),
      .sdo_oe_o     (sdo_oe_o),
      .prog_start_o (prog_start_o),
      .prog_op_o    (op_w),
      .prog_addr_o  (prog_addr_o),
      .prog_cnt_o   (prog_cnt_o),
      .prog_data_o  (prog_data_o),
      .wel_o        (wel_w),
      .busy_o       (busy_w)
   );

   assign prog_op_o = op_w;
   assign commit_w  = prog_done_i & prog_ok_i & busy_w;

   mw_word_array #(.AW(AW), .DW(DW), .PW(PW)) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_i    (commit_w),
      .op_i        (op_w),
      .base_addr_i (prog_addr_o),
      .cnt_i       (prog_cnt_o),
      .wbuf_i      (prog_data_o),
      .rd_addr_i   (rd_addr_w),
      .rd_data_o   (rd_data_w)
   );

endmodule

// File: rtl/mw_eeprom_engine_chk.sv
module mw_eeprom_engine_chk #(
   parameter  int PW = 4,
   localparam int PB = $clog2(PW)
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cs_i,
   input logic        wen_pin_i,
   input logic        sdo_oe_o,
   input logic        prog_start_o,
   input logic [1:0]  prog_op_o,
   input logic [PB:0] prog_cnt_o,
   input logic        wel_i,
   input logic        busy_i
);

   // R12
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_i |=> !sdo_oe_o);

   // R7
   launch_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_start_o) |-> !$past(cs_i));

   // R6
   launch_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_start_o) |-> ($past(wel_i) && $past(wen_pin_i)));

   // R10
   no_launch_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && $past(busy_i)) |-> !prog_start_o);

   // R8
   page_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start_o |-> (prog_cnt_o >= 1 && prog_cnt_o <= (PB+1)'(PW)));

   // R9
   single_word_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_start_o && prog_op_o != 2'd1) |-> (prog_cnt_o == 1));

endmodule

bind mw_eeprom_engine mw_eeprom_engine_chk #(.PW(PW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_i         (cs_i),
   .wen_pin_i    (wen_pin_i),
   .sdo_oe_o     (sdo_oe_o),
   .prog_start_o (prog_start_o),
   .prog_op_o    (prog_op_o),
   .prog_cnt_o   (prog_cnt_o),
   .wel_i        (wel_w),
   .busy_i       (busy_w)
);

// File: tb/mw_eeprom_engine_tb_top.sv
module mw_eeprom_engine_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0, sck = 1'b0, sdi = 1'b0, wpin = 1'b1;
   logic        pdone = 1'b0, pok = 1'b0;
   logic        sdo, oe, pstart;
   logic [1:0]  pop;
   logic [7:0]  paddr;
   logic [2:0]  pcnt;
   logic [63:0] pdata;

   int errs = 0, checks = 0, starts = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   mw_eeprom_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
      .wen_pin_i(wpin), .sdo_o(sdo), .sdo_oe_o(oe), .prog_start_o(pstart),
      .prog_op_o(pop), .prog_addr_o(paddr), .prog_cnt_o(pcnt),
      .prog_data_o(pdata), .prog_done_i(pdone), .prog_ok_i(pok));

   always @(negedge clk) if (pstart) starts++;

   // word address, data
   localparam logic [23:0] VEC [4] = '{24'h00_1234, 24'hFE_BEEF,
                                       24'hFF_0F0F, 24'h37_8001};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n); repeat (n) @(negedge clk); endtask
   task automatic bitx(input logic b); sck = 1'b0; sdi = b; tick(3); sck = 1'b1; tick(3); endtask
   task automatic sel_on(); sck = 1'b0; tick(1); cs = 1'b1; tick(2); endtask
   task automatic sel_off(); cs = 1'b0; tick(3); sck = 1'b0; tick(1); endtask

   task automatic head(input logic [1:0] op, input logic [7:0] a);
      sel_on(); bitx(1'b1); bitx(op[1]); bitx(op[0]);
      for (int i = 7; i >= 0; i--) bitx(a[i]);
   endtask
   task automatic word(input logic [15:0] d);
      for (int i = 15; i >= 0; i--) bitx(d[i]);
   endtask

   task automatic finish_prog(input logic ok, input string req);
      sel_on();
      chk({req, " R10 busy"}, {62'd0, oe, sdo}, 64'h2);
      pok = ok; pdone = 1'b1; tick(1); pdone = 1'b0; tick(2);
      chk({req, " R10 ready"}, {62'd0, oe, sdo}, 64'h3);
      sel_off();
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] w);
      head(2'b10, a);
      chk("R3 dummy", {62'd0, oe, sdo}, 64'h2);
      w = '0;
      for (int i = 0; i < 16; i++) begin bitx(1'b0); w = {w[14:0], sdo}; end
      sel_off();
      chk("R12 released", {63'd0, oe}, 64'd0);
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      head(2'b01, a); word(d); sel_off();
   endtask

   initial begin
      logic [15:0] w;
      int s0;
      tick(3); rst_n = 1'b1; tick(2);
      // R1 reset state
      chk("R1 oe", {63'd0, oe}, 64'd0);
      chk("R1 start", {63'd0, pstart}, 64'd0);
      wr(8'h12, 16'hFFFF);
      chk("R1 latch clear R6", starts, 0);
      rd(8'h12, w); chk("R1 array zero", w, 64'd0);

      // R5 set latch, then walk vector table (R7 R3)
      head(2'b00, 8'hC0); sel_off();
      for (int i = 0; i < 4; i++) begin
         s0 = starts;
         wr(VEC[i][23:16], VEC[i][15:0]);
         chk("R7 launch", starts, s0 + 1);
         chk("R7 fields", {pop, pcnt, paddr, pdata[15:0]},
             {2'd0, 3'd1, VEC[i][23:16], VEC[i][15:0]});
         finish_prog(1'b1, "R7");
      end
      for (int i = 0; i < 4; i++) begin
         rd(VEC[i][23:16], w); chk("R3 readback", w, VEC[i][15:0]);
      end

      // R4 sequential read FE, FF, wrap to 00
      head(2'b10, 8'hFE);
      chk("R4 dummy", {63'd0, sdo}, 64'd0);
      for (int k = 0; k < 3; k++) begin
         w = '0;
         for (int i = 0; i < 16; i++) begin bitx(1'b0); w = {w[14:0], sdo}; end
         chk("R4 stream", w, (k == 0) ? 16'hBEEF : (k == 1) ? 16'h0F0F : 16'h1234);
      end
      sel_off();

      // R2 leading zeros before start bit
      sel_on();
      chk("R12 idle select", {63'd0, oe}, 64'd0);
      bitx(1'b0); bitx(1'b0); bitx(1'b1); bitx(1'b1); bitx(1'b0);
      for (int i = 7; i >= 0; i--) bitx(i != 0);
      w = '0;
      for (int i = 0; i < 16; i++) begin bitx(1'b0); w = {w[14:0], sdo}; end
      chk("R2 leading zeros", w, 16'hBEEF);
      sel_off();

      // R2 select rising with clock high: no frame
      sck = 1'b1; tick(1); cs = 1'b1; tick(2);
      bitx(1'b1); bitx(1'b1); bitx(1'b0);
      for (int i = 0; i < 9; i++) bitx(1'b0);
      chk("R2 no frame", {63'd0, oe}, 64'd0);
      sel_off();

      // R7 window: early and late deselect
      s0 = starts;
      head(2'b01, 8'h31); for (int i = 0; i < 10; i++) bitx(1'b1); sel_off();
      chk("R7 early", starts, s0);
      head(2'b01, 8'h31); word(16'h7777); bitx(1'b0); sel_off();
      chk("R7 late", starts, s0);

      // R6 pin low
      wpin = 1'b0; wr(8'h30, 16'h4321); wpin = 1'b1;
      chk("R6 pin", starts, s0);
      rd(8'h30, w); chk("R6 pin array", w, 64'd0);

      // R11 rejected request
      wr(8'h37, 16'h0000); chk("R11 launch", starts, s0 + 1);
      finish_prog(1'b0, "R11");
      rd(8'h37, w); chk("R11 unchanged", w, 16'h8001);

      // R8 page write with wrap inside the page
      s0 = starts;
      head(2'b11, 8'h46);
      word(16'hA000); word(16'hA001); word(16'hA002); word(16'hA003);
      sel_off();
      chk("R8 page req", {pop, pcnt, paddr}, {2'd1, 3'd4, 8'h46});
      finish_prog(1'b1, "R8");
      rd(8'h44, w); chk("R8 wrap 44", w, 16'hA002);
      rd(8'h45, w); chk("R8 wrap 45", w, 16'hA003);
      rd(8'h46, w); chk("R8 page 46", w, 16'hA000);
      rd(8'h47, w); chk("R8 page 47", w, 16'hA001);
      rd(8'h48, w); chk("R8 outside page", w, 64'd0);
      s0 = starts;
      head(2'b11, 8'h50);
      for (int i = 0; i < 4; i++) word(16'h1111); bitx(1'b1); sel_off();
      chk("R8 fifth word cancels", starts, s0);

      // R10 input ignored while busy
      wr(8'h20, 16'hAAAA);
      sel_on();
      bitx(1'b1); bitx(1'b1); bitx(1'b0);
      for (int i = 0; i < 8; i++) bitx(1'b0);
      chk("R10 ignored busy", {62'd0, oe, sdo}, 64'h2);
      pok = 1'b1; pdone = 1'b1; tick(1); pdone = 1'b0; tick(2);
      chk("R10 ready", {62'd0, oe, sdo}, 64'h3);
      bitx(1'b0);
      chk("R10 ready holds", {62'd0, oe, sdo}, 64'h3);
      bitx(1'b1);
      chk("R10 start clears", {63'd0, oe}, 64'd0);
      sel_off();
      rd(8'h20, w); chk("R10 commit", w, 16'hAAAA);

      // R5 clear latch: write ignored, read still works
      s0 = starts;
      head(2'b00, 8'h00); sel_off();
      wr(8'h21, 16'h5555); chk("R5 cleared", starts, s0);
      rd(8'h20, w); chk("R5 read unaffected", w, 16'hAAAA);

      // R9 whole-array write
      head(2'b00, 8'hC0); sel_off();
      head(2'b00, 8'h40); word(16'h5A5A); sel_off();
      chk("R9 req", {pop, pcnt, pdata[15:0]}, {2'd2, 3'd1, 16'h5A5A});
      finish_prog(1'b1, "R9");
      rd(8'h10, w); chk("R9 all 10", w, 16'h5A5A);
      rd(8'hFF, w); chk("R9 all FF", w, 16'h5A5A);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errs++;
         $display("FAIL watchdog actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule